// File: doc/BRIEF.md
# BCD Clock Calendar Timekeeper

This block keeps time of day and calendar date as seven packed-BCD registers: seconds, minutes, hours, day of week, date, month and year. A reference enable, nominally 32.768 kHz, is divided down to a one-second step. Each step carries through the fields in turn: seconds, minutes, hours and then the calendar. The date field knows the length of every month, including February in leap years.

Host logic sets the time through a byte-wide register write port. All seven registers are presented at once on a flat snapshot bus, so a reader sees a coherent set. A halt flag in the seconds register freezes counting. A mode flag in the hours register chooses between a 24-hour dial and a 12-hour dial with a PM flag.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the snapshot reads 00:00:00 in 24-hour mode, running, day of week 1, date 01, month 01, year 00.
- R2: A write stores `wr_data` ANDed with the register's mask, and the snapshot shows it after the next rising edge. Address and mask pairs are: 0 seconds FF, 1 minutes 7F, 2 hours 7F, 3 day of week 07, 4 date 3F, 5 month 1F, 6 year FF. A write to address 7 changes nothing. Register i occupies snapshot bits [8i+7:8i].
- R3: Every TICK_DIV-th cycle with `ref_en` high is one second. Seconds run from 00 to 59 and then wrap to 00 while minutes advance. Minutes wrap the same way and advance the hour.
- R4: While bit 7 of register 0 is 1, no field advances. Clearing it resumes counting.
- R5: With hours bit 6 = 0 (24-hour mode), bits 5:0 hold BCD 00..23, so bit 5 is the tens-of-twenty digit. 23 wraps to 00 and advances the calendar.
- R6: With hours bit 6 = 1 (12-hour mode), bits 4:0 hold BCD 01..12 and bit 5 is PM. Going from 11 to 12 toggles PM. Going from 12 to 01 keeps PM. The calendar advances only on 11 PM to 12 AM.
- R7: Day of week counts 1..7 in bits 2:0 and wraps from 7 to 1 at each day change.
- R8: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Month 12 wraps to 01 and advances the year.
- R9: February ends at 29 when the year value is divisible by four and at 28 otherwise. Year 99 wraps to 00.
- R10: When a write and a one-second step fall in the same cycle, the write is applied and that step is discarded in every field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference enable, one pulse per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| time_o | output | 56 | Snapshot of all seven registers |

## Verification
A host write and the one-second step can land on the same edge. The bench provokes this by running the reference enable up to one pulse short of the divider terminal count. It then raises the write strobe in the very cycle of the final pulse. The bench judges the result by checking three things: the written register holds the new byte, the seconds field did not move, and the next full divider period advances seconds by exactly one. This shows the divider stayed aligned while the step was dropped.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int NREG = 7;
  localparam int AW   = 3;

  localparam logic [AW-1:0] A_SEC   = 3'd0;
  localparam logic [AW-1:0] A_MIN   = 3'd1;
  localparam logic [AW-1:0] A_HOUR  = 3'd2;
  localparam logic [AW-1:0] A_DOW   = 3'd3;
  localparam logic [AW-1:0] A_DATE  = 3'd4;
  localparam logic [AW-1:0] A_MONTH = 3'd5;
  localparam logic [AW-1:0] A_YEAR  = 3'd6;

  function automatic logic [7:0] reg_mask(input logic [AW-1:0] a);
    case (a)
      A_SEC:   return 8'hFF;
      A_MIN:   return 8'h7F;
      A_HOUR:  return 8'h7F;
      A_DOW:   return 8'h07;
      A_DATE:  return 8'h3F;
      A_MONTH: return 8'h1F;
      A_YEAR:  return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // two-digit BCD increment, low digit wraps at 9
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divisible by four, judged on the BCD digits directly
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return bcd_leap(y) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_next(input logic [7:0] h);
    logic [7:0] inc;
    inc = 8'h00;
    if (h[6]) begin
      inc = bcd_inc({3'b000, h[4:0]});
      if (h[4:0] == 5'h11)      return {2'b01, ~h[5], 5'h12};
      else if (h[4:0] == 5'h12) return {2'b01, h[5], 5'h01};
      else                      return {2'b01, h[5], inc[4:0]};
    end else begin
      inc = bcd_inc({2'b00, h[5:0]});
      if (h[5:0] == 6'h23) return 8'h00;
      else                 return {2'b00, inc[5:0]};
    end
  endfunction

  function automatic logic hour_ends_day(input logic [7:0] h);
    if (h[6]) return (h[4:0] == 5'h11) && h[5];
    else      return (h[5:0] == 6'h23);
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = ref_en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (ref_en) cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ref_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tk_clock_regs.sv
module tk_clock_regs
  import tk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    sec_o,
  output logic [7:0]    min_o,
  output logic [7:0]    hour_o,
  output logic          halt_o,
  output logic          day_carry_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] sec_d, min_d, hour_d;
  logic [7:0] sec_inc, min_inc;
  logic       sec_wrap, min_wrap, load;

  assign sec_inc  = bcd_inc({1'b0, sec_q[6:0]});
  assign min_inc  = bcd_inc({1'b0, min_q[6:0]});
  assign sec_wrap = (sec_q[6:0] == 7'h59);
  assign min_wrap = (min_q[6:0] == 7'h59);
  assign load     = wr_en | step;

  assign day_carry_o = step && sec_wrap && min_wrap && hour_ends_day(hour_q);

  always_comb begin
    sec_d  = sec_q;
    min_d  = min_q;
    hour_d = hour_q;
    if (wr_en) begin
      case (wr_addr)
        A_SEC:   sec_d  = wr_data & reg_mask(A_SEC);
        A_MIN:   min_d  = wr_data & reg_mask(A_MIN);
        A_HOUR:  hour_d = wr_data & reg_mask(A_HOUR);
        default: ;
      endcase
    end else if (step) begin
      sec_d = {sec_q[7], sec_wrap ? 7'h00 : sec_inc[6:0]};
      if (sec_wrap) begin
        min_d = min_wrap ? 8'h00 : {1'b0, min_inc[6:0]};
        if (min_wrap) hour_d = hour_next(hour_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (load) begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign halt_o = sec_q[7];
endmodule

// File: rtl/tk_calendar_regs.sv
module tk_calendar_regs
  import tk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          day_step,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    dow_o,
  output logic [7:0]    date_o,
  output logic [7:0]    month_o,
  output logic [7:0]    year_o
);
  logic [2:0] dow_q, dow_d;
  logic [5:0] date_q, date_d;
  logic [4:0] month_q, month_d;
  logic [7:0] year_q, year_d;
  logic [7:0] date_inc, month_inc, year_inc;
  logic [5:0] last;
  logic       load;

  assign date_inc  = bcd_inc({2'b00, date_q});
  assign month_inc = bcd_inc({3'b000, month_q});
  assign year_inc  = bcd_inc(year_q);
  assign last      = month_last(month_q, year_q);
  assign load      = wr_en | day_step;

  always_comb begin
    dow_d   = dow_q;
    date_d  = date_q;
    month_d = month_q;
    year_d  = year_q;
    if (wr_en) begin
      case (wr_addr)
        A_DOW:   dow_d   = wr_data[2:0];
        A_DATE:  date_d  = wr_data[5:0];
        A_MONTH: month_d = wr_data[4:0];
        A_YEAR:  year_d  = wr_data;
        default: ;
      endcase
    end else if (day_step) begin
      dow_d = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (date_q == last) begin
        date_d = 6'h01;
        if (month_q == 5'h12) begin
          month_d = 5'h01;
          year_d  = (year_q == 8'h99) ? 8'h00 : year_inc;
        end else begin
          month_d = month_inc[4:0];
        end
      end else begin
        date_d = date_inc[5:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 3'd1;
      date_q  <= 6'h01;
      month_q <= 5'h01;
      year_q  <= 8'h00;
    end else if (load) begin
      dow_q   <= dow_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
    end
  end

  assign dow_o   = {5'b0, dow_q};
  assign date_o  = {2'b0, date_q};
  assign month_o = {3'b0, month_q};
  assign year_o  = year_q;
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] time_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       tick, halt, step, day_carry;
  logic [7:0] regs_w [NREG];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tk_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ref_en (ref_en),
    .tick   (tick)
  );

  // a write in the same cycle drops the step entirely
  assign step = tick & ~halt & ~wr_en;

  tk_clock_regs u_clock (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .step        (step),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .sec_o       (regs_w[0]),
    .min_o       (regs_w[1]),
    .hour_o      (regs_w[2]),
    .halt_o      (halt),
    .day_carry_o (day_carry)
  );

  tk_calendar_regs u_cal (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .day_step (day_carry),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dow_o    (regs_w[3]),
    .date_o   (regs_w[4]),
    .month_o  (regs_w[5]),
    .year_o   (regs_w[6])
  );

  for (genvar i = 0; i < NREG; i++) begin : g_snap
    assign time_o[8*i +: 8] = regs_w[i];
  end
endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] snap
);
  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < 3'd7) |=>
      snap[8*int'($past(wr_addr)) +: 8] == ($past(wr_data) & reg_mask($past(wr_addr))));

  // R2
  wr_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7) |=> $stable(snap));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap[7] && !wr_en) |=> $stable(snap));

  // R3
  no_ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !wr_en) |=> $stable(snap));

  // R3
  sec_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && snap[6:0] == 7'h59) |=> (snap[6:0] == 7'h59 || snap[6:0] == 7'h00));

  // R3
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && snap[6:0] != 7'h59) |=> $stable(snap[15:8]));

  // R7
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && snap[26:24] == 3'd7) |=> (snap[26:24] == 3'd7 || snap[26:24] == 3'd1));
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .ref_en  (ref_en),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .snap    (time_o)
);

// File: tb/bcd_timekeeper_bench.sv
`timescale 1ns/1ps
module bcd_timekeeper_bench;
  localparam int DIV = 4;

  logic        clk;
  logic        rst_n;
  logic        ref_en;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [55:0] time_o;

  int total = 0;
  int bad   = 0;

  bcd_timekeeper #(.TICK_DIV(DIV)) u_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .time_o(time_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] tobcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] rb(input int idx);
    return time_o[8*idx +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1();
    ref_en = 1'b1;
    repeat (DIV) @(negedge clk);
    ref_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [55:0] snap_before;
    rst_n = 1'b0; ref_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 sec",  rb(0), 8'h00);
    chk("R1 min",  rb(1), 8'h00);
    chk("R1 hour", rb(2), 8'h00);
    chk("R1 dow",  rb(3), 8'h01);
    chk("R1 date", rb(4), 8'h01);
    chk("R1 mon",  rb(5), 8'h01);
    chk("R1 year", rb(6), 8'h00);

    // R3 divider: DIV-1 pulses do not advance, the next one does
    ref_en = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    ref_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 early", rb(0), 8'h00);
    ref_en = 1'b1;
    @(negedge clk);
    ref_en = 1'b0;
    chk("R3 tick", rb(0), 8'h01);

    // R3 seconds sweep and minute carry
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    for (int i = 1; i <= 60; i++) begin
      tick1();
      chk("R3 sec sweep", rb(0), tobcd(i % 60));
    end
    chk("R3 min carry", rb(1), 8'h01);
    wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h05);
    tick1();
    chk("R3 hour carry", rb(2), 8'h06);

    // R2 masks and void address
    wr(3'd1, 8'hFF); chk("R2 min mask",  rb(1), 8'h7F);
    wr(3'd2, 8'hFF); chk("R2 hour mask", rb(2), 8'h7F);
    wr(3'd3, 8'hFF); chk("R2 dow mask",  rb(3), 8'h07);
    wr(3'd4, 8'hFF); chk("R2 date mask", rb(4), 8'h3F);
    wr(3'd5, 8'hFF); chk("R2 mon mask",  rb(5), 8'h1F);
    wr(3'd6, 8'hA5); chk("R2 year",      rb(6), 8'hA5);
    snap_before = time_o;
    wr(3'd7, 8'h3C);
    for (int k = 0; k < 7; k++) chk("R2 addr7 void", rb(k), snap_before[8*k +: 8]);

    // R4 halt
    wr(3'd0, 8'h90); wr(3'd1, 8'h12);
    repeat (3) tick1();
    chk("R4 halted sec", rb(0), 8'h90);
    chk("R4 halted min", rb(1), 8'h12);
    wr(3'd0, 8'h10);
    tick1();
    chk("R4 resumed", rb(0), 8'h11);

    // R5 24-hour sweep, R7 via day change
    for (int h = 0; h < 24; h++) begin
      wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, tobcd(h));
      wr(3'd3, 8'h03); wr(3'd4, 8'h01); wr(3'd5, 8'h01);
      tick1();
      chk("R5 hour24", rb(2), tobcd((h + 1) % 24));
      chk("R5 min",    rb(1), 8'h00);
      chk("R5 dow",    rb(3), (h == 23) ? 8'h04 : 8'h03);
    end

    // R6 12-hour sweep
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh; int npm; int dc;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        dc  = (h == 11 && pm == 1) ? 1 : 0;
        wr(3'd0, 8'h59); wr(3'd1, 8'h59);
        wr(3'd2, 8'h40 | (pm ? 8'h20 : 8'h00) | tobcd(h));
        wr(3'd3, 8'h05); wr(3'd4, 8'h01); wr(3'd5, 8'h01);
        tick1();
        chk("R6 hour12", rb(2), 8'h40 | (npm ? 8'h20 : 8'h00) | tobcd(nh));
        chk("R6 dow",    rb(3), dc ? 8'h06 : 8'h05);
      end
    end

    // R7 explicit wrap
    wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd3, 8'h07);
    tick1();
    chk("R7 dow wrap", rb(3), 8'h01);

    // R8 / R9 calendar sweep over every month of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        for (int e = 0; e < 2; e++) begin
          int last; int d; int xd; int xm; int xy;
          last = days_in(m, y);
          d  = last - 1 + e;
          xd = (e == 1) ? 1 : d + 1;
          xm = (e == 1) ? ((m == 12) ? 1 : m + 1) : m;
          xy = (e == 1 && m == 12) ? (y + 1) % 100 : y;
          wr(3'd0, 8'h59); wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd3, 8'h07);
          wr(3'd4, tobcd(d)); wr(3'd5, tobcd(m)); wr(3'd6, tobcd(y));
          tick1();
          chk((m == 2) ? "R9 feb date" : "R8 date", rb(4), tobcd(xd));
          chk("R8 month", rb(5), tobcd(xm));
          chk("R9 year",  rb(6), tobcd(xy));
          chk("R7 dow",   rb(3), 8'h01);
        end
      end
    end

    // R10 write collides with the step
    wr(3'd0, 8'h20); wr(3'd1, 8'h30);
    ref_en = 1'b1;
    repeat (DIV - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h42;
    @(negedge clk);
    wr_en = 1'b0; ref_en = 1'b0;
    chk("R10 written", rb(6), 8'h42);
    chk("R10 sec held", rb(0), 8'h20);
    chk("R10 min held", rb(1), 8'h30);
    tick1();
    chk("R10 realigned", rb(0), 8'h21);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule